// File: doc/BRIEF.md
# Six-Bit ALU with Two-Step Carry and Zero Flags

This unit does the arithmetic, logic, increment/decrement and rotate work of a small 6-bit processor. Each operation takes two execution steps. In the first step the unit works out a 6-bit result from the accumulator, a register operand and the committed carry. It holds that result in an internal transfer register and holds the new carry as a pending value. In the second step the unit copies the pending carry into the carry flag and sets the zero flag from the held result. Each operation writes only its own fixed subset of the two flags.

A sequencer outside the unit supplies the operands and pulses `step1`, then `step2`. It reads the held result to write it back wherever the instruction needs it. It reads `skip` to drop the next instruction after a decrement-and-skip. Operand fetch and writeback routing are outside this block.

Top module: `alu6_flags`

## Requirements
- R1: ADD (opSel 1) gives (acc + regOp) mod 64. Its pending carry is the carry out of bit 5.
- R2: SUB (opSel 2) gives (acc - regOp) mod 64. Its pending carry is 1 when acc >= regOp (no borrow) and 0 when a borrow occurs.
- R3: ROL (opSel 11) gives {regOp[4:0], carryFlag} with pending carry regOp[5]. ROR (opSel 12) gives {carryFlag, regOp[5:1]} with pending carry regOp[0]. The six bits and the carry together act as a 7-bit ring.
- R4: The following operations produce these results:
  - opSel 0 (load) gives regOp.
  - opSel 3 gives acc & regOp.
  - opSel 4 gives acc | regOp.
  - opSel 5 gives acc ^ regOp.
  - opSel 6 gives ~regOp.
  - opSel 10 (clear) gives 0.
- R5: INC (opSel 7) gives regOp + 1 mod 64 and DEC (opSel 8) gives regOp - 1 mod 64. Neither one changes the carry flag.
- R6: On `step2`, the zero flag becomes 1 if the held result is 0 and becomes 0 otherwise. This happens only for opSel 0 through 8 and opSel 10. For every other opSel the zero flag keeps its value.
- R7: On `step2`, the carry flag takes the pending carry. This happens only for opSel 1, 2, 11, 12, 13 and 14. For every other opSel the carry flag keeps its value.
- R8: The result and the pending carry are captured on the clock edge where `step1` is high. Operations that do not write the carry leave a pending carry of 0. Neither flag changes on a `step1` edge.
- R9: DSZ (opSel 9) gives regOp - 1 mod 64 and changes neither flag. `skip` is high while the held operation is DSZ and its held result is 0. In every other case `skip` is low.
- R10: SAC (opSel 15) gives the carry flag as a 6-bit value, 0 or 1.
- R11: CLC (opSel 13) and SEC (opSel 14) give result 0 and pending carry 0 or 1 respectively. That value reaches the carry flag on `step2`.
- R12: After reset, result, carryPend, carryFlag, zeroFlag and skip are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 4 | Operation select, sampled on step1 |
| acc | input | 6 | Accumulator operand |
| regOp | input | 6 | Register operand |
| step1 | input | 1 | Compute strobe: capture result and pending carry |
| step2 | input | 1 | Commit strobe: update flags for the held operation |
| result | output | 6 | Held result (transfer register) |
| carryPend | output | 1 | Pending carry |
| carryFlag | output | 1 | Committed carry flag |
| zeroFlag | output | 1 | Committed zero flag |
| skip | output | 1 | Decrement-and-skip reached zero |

## Verification
The bench sweeps ADD, SUB and the three two-operand logic operations over every pair of operands. It sweeps the single-operand operations over every register value. Each rotate is run with both carry-in values, so a rotate that dropped the carry or fed it in at the wrong end would break the ring at the bit 5 or bit 0 corners. A SUB with the borrow polarity reversed would fail on every equal-operand case. An INC, DEC or DSZ that touched a flag would show up because the flags are checked after every commit. The bench also compares the flags against the model between the two steps, so a design that committed flags during the compute step would be caught.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

  typedef enum logic [3:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_NOT  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_DSZ  = 4'd9,
    OP_CLR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_CLC  = 4'd13,
    OP_SEC  = 4'd14,
    OP_SAC  = 4'd15
  } aluOp_e;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic loadTr;
    logic commitCarry;
    logic commitZero;
    logic heldDsz;
  } aluStrobe_t;

  function automatic logic writesCarry(aluOp_e op);
    case (op)
      OP_ADD, OP_SUB, OP_ROL, OP_ROR, OP_CLC, OP_SEC: writesCarry = 1'b1;
      default:                                        writesCarry = 1'b0;
    endcase
  endfunction

  function automatic logic writesZero(aluOp_e op);
    case (op)
      OP_PASS, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
      OP_NOT, OP_INC, OP_DEC, OP_CLR: writesZero = 1'b1;
      default:                        writesZero = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu6_ctrl.sv
module alu6_ctrl
  import alu6_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  aluOp_e     opNow,
  input  logic       step1,
  input  logic       step2,
  output aluStrobe_t strobe
);

  // The operation captured in step 1 decides which flags step 2 commits.
  aluOp_e opHeld;

  always_ff @(posedge clk) begin
    if (!rstN) opHeld <= OP_PASS;
    else if (step1) opHeld <= opNow;
  end

  always_comb begin
    strobe.loadTr      = step1;
    strobe.commitCarry = step2 && writesCarry(opHeld);
    strobe.commitZero  = step2 && writesZero(opHeld);
    strobe.heldDsz     = (opHeld == OP_DSZ);
  end

endmodule

// File: rtl/alu6_datapath.sv
module alu6_datapath
  import alu6_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluOp_e       opNow,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] regIn,
  input  aluStrobe_t   strobe,
  output logic [W-1:0] trOut,
  output logic         pendOut,
  output logic         carryOut,
  output logic         zeroOut,
  output logic         skipOut
);

  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W:0]   sumWide;
  logic [W:0]   diffWide;
  logic [W-1:0] calcRes;
  logic         calcCarry;
  logic [W-1:0] trReg;
  logic         pendReg;
  logic         carryReg;
  logic         zeroReg;

  assign sumWide  = {1'b0, accIn} + {1'b0, regIn};
  assign diffWide = {1'b0, accIn} - {1'b0, regIn};

  always_comb begin
    calcRes   = ZERO;
    calcCarry = 1'b0;
    case (opNow)
      OP_PASS: calcRes = regIn;
      OP_ADD: begin
        calcRes   = sumWide[MSB:0];
        calcCarry = sumWide[W];
      end
      OP_SUB: begin
        calcRes   = diffWide[MSB:0];
        calcCarry = ~diffWide[W];
      end
      OP_AND:  calcRes = accIn & regIn;
      OP_OR:   calcRes = accIn | regIn;
      OP_XOR:  calcRes = accIn ^ regIn;
      OP_NOT:  calcRes = ~regIn;
      OP_INC:  calcRes = regIn + ONE;
      OP_DEC, OP_DSZ: calcRes = regIn - ONE;
      OP_CLR:  calcRes = ZERO;
      OP_ROL: begin
        calcRes   = {regIn[MSB-1:0], carryReg};
        calcCarry = regIn[MSB];
      end
      OP_ROR: begin
        calcRes   = {carryReg, regIn[MSB:1]};
        calcCarry = regIn[0];
      end
      OP_CLC:  calcCarry = 1'b0;
      OP_SEC:  calcCarry = 1'b1;
      OP_SAC:  calcRes = {{(W-1){1'b0}}, carryReg};
      default: calcRes = ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trReg    <= ZERO;
      pendReg  <= 1'b0;
      carryReg <= 1'b0;
      zeroReg  <= 1'b0;
    end else begin
      if (strobe.loadTr) begin
        trReg   <= calcRes;
        pendReg <= calcCarry;
      end
      if (strobe.commitCarry) carryReg <= pendReg;
      if (strobe.commitZero)  zeroReg  <= (trReg == ZERO);
    end
  end

  assign trOut    = trReg;
  assign pendOut  = pendReg;
  assign carryOut = carryReg;
  assign zeroOut  = zeroReg;
  assign skipOut  = strobe.heldDsz && (trReg == ZERO);

endmodule

// File: rtl/alu6_flags.sv
module alu6_flags
  import alu6_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opSel,
  input  logic [5:0] acc,
  input  logic [5:0] regOp,
  input  logic       step1,
  input  logic       step2,
  output logic [5:0] result,
  output logic       carryPend,
  output logic       carryFlag,
  output logic       zeroFlag,
  output logic       skip
);

  aluOp_e     opNow;
  aluStrobe_t strobe;

  assign opNow = aluOp_e'(opSel);

  alu6_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .opNow  (opNow),
    .step1  (step1),
    .step2  (step2),
    .strobe (strobe)
  );

  alu6_datapath #(.W(6)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .opNow    (opNow),
    .accIn    (acc),
    .regIn    (regOp),
    .strobe   (strobe),
    .trOut    (result),
    .pendOut  (carryPend),
    .carryOut (carryFlag),
    .zeroOut  (zeroFlag),
    .skipOut  (skip)
  );

endmodule

// File: rtl/alu6_checker.sv
module alu6_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] opSel,
  input logic       step1,
  input logic       step2,
  input logic [5:0] result,
  input logic       carryPend,
  input logic       carryFlag,
  input logic       zeroFlag,
  input logic       skip
);

  a_r8_carry_waits_step2: assert property (@(posedge clk) disable iff (!rstN)
    !step2 |=> $stable(carryFlag));

  a_r6_zero_waits_step2: assert property (@(posedge clk) disable iff (!rstN)
    !step2 |=> $stable(zeroFlag));

  a_r9_skip_needs_zero: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> (result == 6'd0));

  a_r11_sec_pending: assert property (@(posedge clk) disable iff (!rstN)
    (step1 && opSel == 4'd14) |=> (carryPend && result == 6'd0));

  a_r11_clc_pending: assert property (@(posedge clk) disable iff (!rstN)
    (step1 && opSel == 4'd13) |=> (!carryPend && result == 6'd0));

  a_r4_clear_result: assert property (@(posedge clk) disable iff (!rstN)
    (step1 && opSel == 4'd10) |=> (result == 6'd0));

  a_r10_sac_range: assert property (@(posedge clk) disable iff (!rstN)
    (step1 && opSel == 4'd15) |=> (result[5:1] == 5'd0));

  a_r5_inc_no_pending: assert property (@(posedge clk) disable iff (!rstN)
    (step1 && opSel == 4'd7) |=> !carryPend);

endmodule

bind alu6_flags alu6_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opSel     (opSel),
  .step1     (step1),
  .step2     (step2),
  .result    (result),
  .carryPend (carryPend),
  .carryFlag (carryFlag),
  .zeroFlag  (zeroFlag),
  .skip      (skip)
);

// File: tb/tb_alu6_flags.sv
module tb_alu6_flags;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opSel = '0;
  logic [5:0] acc = '0;
  logic [5:0] regOp = '0;
  logic       step1 = 1'b0;
  logic       step2 = 1'b0;
  logic [5:0] result;
  logic       carryPend;
  logic       carryFlag;
  logic       zeroFlag;
  logic       skip;

  int total = 0;
  int bad = 0;
  logic mC = 1'b0;
  logic mZ = 1'b0;

  always #5 clk = ~clk;

  alu6_flags dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .acc(acc), .regOp(regOp),
    .step1(step1), .step2(step2), .result(result), .carryPend(carryPend),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .skip(skip)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string resTag(input int op);
    case (op)
      1: return "R1";
      2: return "R2";
      11, 12: return "R3";
      7, 8: return "R5";
      9: return "R9";
      15: return "R10";
      13, 14: return "R11";
      default: return "R4";
    endcase
  endfunction

  task automatic runOp(input int op, input logic [5:0] a, input logic [5:0] r);
    logic [6:0] wide;
    logic [5:0] eRes;
    logic eC;
    logic cEn;
    logic zEn;
    eRes = 6'd0; eC = 1'b0;
    cEn = (op == 1 || op == 2 || op == 11 || op == 12 || op == 13 || op == 14);
    zEn = (op <= 8 || op == 10);
    case (op)
      0: eRes = r;
      1: begin wide = {1'b0, a} + {1'b0, r}; eRes = wide[5:0]; eC = wide[6]; end
      2: begin eRes = a - r; eC = (a >= r); end
      3: eRes = a & r;
      4: eRes = a | r;
      5: eRes = a ^ r;
      6: eRes = ~r;
      7: eRes = r + 6'd1;
      8, 9: eRes = r - 6'd1;
      10: eRes = 6'd0;
      11: begin eRes = {r[4:0], mC}; eC = r[5]; end
      12: begin eRes = {mC, r[5:1]}; eC = r[0]; end
      13: eC = 1'b0;
      14: eC = 1'b1;
      15: eRes = {5'd0, mC};
      default: eRes = 6'd0;
    endcase
    @(negedge clk);
    opSel = 4'(op); acc = a; regOp = r; step1 = 1'b1;
    @(negedge clk);
    step1 = 1'b0;
    chk(resTag(op), int'(result), int'(eRes));
    chk(cEn ? resTag(op) : "R8 pending zero", int'(carryPend), int'(eC));
    chk("R9 skip", int'(skip), int'(op == 9 && eRes == 6'd0));
    chk("R8 carry held before step2", int'(carryFlag), int'(mC));
    chk("R8 zero held before step2", int'(zeroFlag), int'(mZ));
    step2 = 1'b1;
    @(negedge clk);
    step2 = 1'b0;
    if (cEn) mC = eC;
    if (zEn) mZ = (eRes == 6'd0);
    chk((op == 7 || op == 8) ? "R5 carry kept" : "R7 carry flag", int'(carryFlag), int'(mC));
    chk("R6 zero flag", int'(zeroFlag), int'(mZ));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 result", int'(result), 0);
    chk("R12 carryPend", int'(carryPend), 0);
    chk("R12 carryFlag", int'(carryFlag), 0);
    chk("R12 zeroFlag", int'(zeroFlag), 0);
    chk("R12 skip", int'(skip), 0);
    rstN = 1'b1;
    // R1, R2 and the two-operand logic ops of R4: every operand pair
    for (int op = 1; op <= 5; op++)
      for (int a = 0; a < 64; a++)
        for (int r = 0; r < 64; r++)
          runOp(op, 6'(a), 6'(r));
    // R4, R5, R9: single-operand ops over every register value
    for (int r = 0; r < 64; r++) begin
      runOp(0, 6'(r ^ 21), 6'(r));
      runOp(6, 6'(r), 6'(r));
      runOp(7, 6'(63 - r), 6'(r));
      runOp(8, 6'(r), 6'(r));
      runOp(9, 6'(r), 6'(r));
      runOp(10, 6'(r), 6'(r));
    end
    // R3 with both carry-in values, R10 and R11 in between
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 64; r++) begin
        runOp(c ? 14 : 13, 6'd0, 6'd0);
        runOp(15, 6'(r), 6'(r));
        runOp(11, 6'd0, 6'(r));
        runOp(c ? 14 : 13, 6'd0, 6'd0);
        runOp(12, 6'd0, 6'(r));
      end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule